// File: doc/BRIEF.md
# USB Host Controller Register Bank

This block is the software-visible register set of a full-speed USB host controller. A simple bus with a byte address, a write strobe and 16-bit data reaches a command word, a status word, an interrupt enable word, the current frame number, a 32-bit frame list pointer split into two halves, a frame length trim value and one status/control word per root port. Reads are combinational from the selected register.

The schedule engine reports completions, errors, resume signalling, system and process faults, and the end of each frame through single-cycle pulses. The port logic supplies connect, line state, speed and over-current levels, plus a pulse when it disables a port. The bank latches these into sticky bits that software clears by writing ones, tracks whether the controller has halted, and raises one level interrupt from the enabled and the non-maskable causes. Writing the controller reset bit returns the whole bank to its initial state one cycle later.

Top module: `usbhc_regbank`

## Requirements
- R1: After reset the words read: command 0x0000, status 0x0020, interrupt enable 0x0000, frame number 0x0000, both frame list halves 0x0000, frame trim 0x0040, each port 0x0080 while its inputs are low; irq is low.
- R2: Command word at offset 0 stores bits 7:0 (bit 0 run, 1 controller reset, 2 bus reset, 3 suspend, 4 resume, 5 debug, 6 configured, 7 packet size 64) and reads bits 15:8 as zero; bits 0, 2, 3, 4, 5 and 7 drive run, glb_reset, glb_susp, glb_resume, sw_debug and maxp_64.
- R3: Status word at offset 2, bits 4:0 (0 completion, 1 error, 2 resume, 3 system error, 4 process error) are set one cycle after ev_ioc, ev_err, ev_resume, ev_hse, ev_perr; writing a one clears a bit, writing zero does nothing, and an event in the same cycle as the clearing write leaves the bit set.
- R4: Status bit 5 (halted) is read-only: it is cleared by a command write with bit 0 set, and set by a frame_end pulse while run is 0; frame_end while running leaves it clear.
- R5: Interrupt enable at offset 4 stores bits 3:0 (0 timeout/error, 1 resume, 2 completion, 3 short packet); irq is high when completion&enable2, error&enable0, resume&enable1, system error, or process error holds.
- R6: A command write with bit 1 set reads back with bit 1 set for one cycle; at the following edge every register returns to its R1 value.
- R7: Frame number at offset 6 holds FRNUM_W bits, is writable, counts up by one on frame_end while run is 1 and wraps from all ones to zero; a write beats the count, higher bits read zero.
- R8: Frame list pointer: offset 8 holds bits 15:0 and offset 10 bits 31:16, both read back and drive flist_base.
- R9: Frame trim at offset 12 holds SOF_W bits, resets to SOF_RST (64) and drives sof_trim; higher bits read zero.
- R10: Port word (offset 16 + 2 x port) reads bit 0 connect, 4 D+ (port_line bit 0 of the pair), 5 D- (bit 1), 8 low speed, 10 over-current from the inputs; bit 7 always reads 1; bits 15:13 always read 0.
- R11: Port bit 1 (connect change) and bit 11 (over-current change) set one cycle after the connect or over-current input changes; writing one clears, writing zero does nothing, a change in the clearing cycle wins.
- R12: Port bit 2 (enabled) is written by software and drives port_en_o; a port_dis pulse clears it and sets bit 3 (enable change), which is write-one-to-clear; the pulse beats a same-cycle enabling write.
- R13: Port bits 6 (resume detect), 9 (port reset) and 12 (suspend) are read/write; bits 9 and 12 drive port_rst_o and port_susp_o.
- R14: Odd addresses and offsets with no register read 0 and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the addressed word |
| ev_ioc | input | 1 | Transfer completion pulse |
| ev_err | input | 1 | Transfer error pulse |
| ev_resume | input | 1 | Resume signalling seen pulse |
| ev_hse | input | 1 | System bus fault pulse |
| ev_perr | input | 1 | Schedule process fault pulse |
| frame_end | input | 1 | End of the current frame |
| port_conn | input | NPORTS | Device present per port |
| port_line | input | 2*NPORTS | D+/D- levels, two bits per port |
| port_lowspd | input | NPORTS | Low-speed device per port |
| port_ovc | input | NPORTS | Over-current level per port |
| port_dis | input | NPORTS | Hardware disable pulse per port |
| irq | output | 1 | Interrupt request |
| run | output | 1 | Schedule run |
| glb_reset | output | 1 | Bus reset request |
| glb_susp | output | 1 | Suspend request |
| glb_resume | output | 1 | Resume request |
| sw_debug | output | 1 | Debug mode |
| maxp_64 | output | 1 | 64-byte packet size selected |
| frame_num | output | FRNUM_W | Current frame number |
| flist_base | output | 32 | Frame list pointer |
| sof_trim | output | SOF_W | Frame length trim |
| port_en_o | output | NPORTS | Port enabled |
| port_rst_o | output | NPORTS | Port reset driven |
| port_susp_o | output | NPORTS | Port suspended |

## Verification
The bench builds the bank with FRNUM_W set to 4, so the frame counter wraps after sixteen frames and the roll-over from all ones to zero is checked in a handful of cycles. NPORTS, SOF_W and the address width keep their defaults of two ports, seven trim bits and five address bits, which places the second port's word and offset 20 beyond it within one address space, so port independence and the unmapped decode are both reachable.

// File: rtl/usbhc_regbank_pkg.sv
`timescale 1ns/1ps
package usbhc_regbank_pkg;

  // byte offsets of the words
  localparam int OFS_CMD    = 0;
  localparam int OFS_STS    = 2;
  localparam int OFS_IEN    = 4;
  localparam int OFS_FRNUM  = 6;
  localparam int OFS_FLB_LO = 8;
  localparam int OFS_FLB_HI = 10;
  localparam int OFS_SOF    = 12;
  localparam int OFS_PORT0  = 16;

  // command bits
  localparam int CB_RUN   = 0;
  localparam int CB_HCRST = 1;
  localparam int CB_GRST  = 2;
  localparam int CB_SUSP  = 3;
  localparam int CB_RSM   = 4;
  localparam int CB_DBG   = 5;
  localparam int CB_MAXP  = 7;

  // port write-side bits
  typedef struct packed {
    logic clr_csc;
    logic clr_pec;
    logic clr_occ;
    logic w_en;
    logic w_rdet;
    logic w_rst;
    logic w_susp;
  } port_wr_t;

  // sticky bit: event sets, clearing write drops, event wins
  function automatic logic w1c_next(logic cur, logic ev, logic clr);
    return ev | (cur & ~clr);
  endfunction

  // sts: 0 completion, 1 error, 2 resume, 3 system, 4 process
  // ien: 0 timeout/error, 1 resume, 2 completion
  function automatic logic irq_eval(logic [4:0] sts, logic [2:0] ien);
    return (sts[0] & ien[2]) | (sts[1] & ien[0]) | (sts[2] & ien[1])
         | sts[3] | sts[4];
  endfunction

  function automatic port_wr_t port_wr_decode(logic [15:0] d);
    port_wr_t w;
    w.clr_csc = d[1];
    w.clr_pec = d[3];
    w.clr_occ = d[11];
    w.w_en    = d[2];
    w.w_rdet  = d[6];
    w.w_rst   = d[9];
    w.w_susp  = d[12];
    return w;
  endfunction

  function automatic logic [15:0] port_pack(
    logic conn, logic csc, logic pe, logic pec, logic [1:0] line,
    logic rdet, logic ls, logic prst, logic oc, logic occ, logic susp);
    logic [15:0] v;
    v        = '0;
    v[0]     = conn;
    v[1]     = csc;
    v[2]     = pe;
    v[3]     = pec;
    v[5:4]   = line;
    v[6]     = rdet;
    v[7]     = 1'b1;
    v[8]     = ls;
    v[9]     = prst;
    v[10]    = oc;
    v[11]    = occ;
    v[12]    = susp;
    return v;
  endfunction

endpackage

// File: rtl/usbhc_cmdsts.sv
`timescale 1ns/1ps
module usbhc_cmdsts
  import usbhc_regbank_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       soft_clr,
  input  logic       wr_cmd,
  input  logic       wr_sts,
  input  logic       wr_ien,
  input  logic [7:0] cmd_wd,
  input  logic [4:0] sts_wd,
  input  logic [3:0] ien_wd,
  input  logic [4:0] sts_ev,
  input  logic       frame_end,
  output logic [7:0] cmd_q,
  output logic [5:0] sts_q,
  output logic [3:0] ien_q,
  output logic       irq
);

  logic [4:0] sts_lo;
  logic       halt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
      ien_q <= '0;
    end else if (soft_clr) begin
      cmd_q <= '0;
      ien_q <= '0;
    end else begin
      if (wr_cmd) cmd_q <= cmd_wd;
      if (wr_ien) ien_q <= ien_wd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_lo <= '0;
    end else if (soft_clr) begin
      sts_lo <= '0;
    end else begin
      for (int i = 0; i < 5; i++)
        sts_lo[i] <= w1c_next(sts_lo[i], sts_ev[i], wr_sts & sts_wd[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          halt_q <= 1'b1;
    else if (soft_clr)                   halt_q <= 1'b1;
    else if (wr_cmd && cmd_wd[CB_RUN])   halt_q <= 1'b0;
    else if (!cmd_q[CB_RUN] && frame_end) halt_q <= 1'b1;
  end

  assign sts_q = {halt_q, sts_lo};
  assign irq   = irq_eval(sts_lo, ien_q[2:0]);

endmodule

// File: rtl/usbhc_framereg.sv
`timescale 1ns/1ps
module usbhc_framereg #(
  parameter int FRNUM_W = 11,
  parameter int SOF_W   = 7,
  parameter int SOF_RST = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               soft_clr,
  input  logic               run,
  input  logic               frame_end,
  input  logic               wr_frnum,
  input  logic               wr_flb_lo,
  input  logic               wr_flb_hi,
  input  logic               wr_sof,
  input  logic [15:0]        wd,
  output logic [FRNUM_W-1:0] frnum_q,
  output logic [31:0]        flb_q,
  output logic [SOF_W-1:0]   sof_q
);

  localparam logic [SOF_W-1:0] SOF_INIT = SOF_W'(SOF_RST);

  function automatic logic [FRNUM_W-1:0] frnum_step(logic [FRNUM_W-1:0] cur);
    return cur + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frnum_q <= '0;
      flb_q   <= '0;
      sof_q   <= SOF_INIT;
    end else if (soft_clr) begin
      frnum_q <= '0;
      flb_q   <= '0;
      sof_q   <= SOF_INIT;
    end else begin
      if (wr_frnum)              frnum_q <= wd[FRNUM_W-1:0];
      else if (run && frame_end) frnum_q <= frnum_step(frnum_q);
      if (wr_flb_lo) flb_q[15:0]  <= wd;
      if (wr_flb_hi) flb_q[31:16] <= wd;
      if (wr_sof)    sof_q <= wd[SOF_W-1:0];
    end
  end

endmodule

// File: rtl/usbhc_portreg.sv
`timescale 1ns/1ps
module usbhc_portreg
  import usbhc_regbank_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        soft_clr,
  input  logic        wr,
  input  port_wr_t    wb,
  input  logic        conn,
  input  logic [1:0]  line,
  input  logic        lowspd,
  input  logic        ovc,
  input  logic        dis_ev,
  output logic [15:0] rd,
  output logic        en_o,
  output logic        rst_o,
  output logic        susp_o
);

  logic conn_q, ovc_q, csc, occ, pe, pec, rdet, prst, susp;
  logic conn_chg, ovc_chg;

  assign conn_chg = conn ^ conn_q;
  assign ovc_chg  = ovc ^ ovc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {conn_q, ovc_q, csc, occ, pe, pec, rdet, prst, susp} <= '0;
    end else if (soft_clr) begin
      {conn_q, ovc_q, csc, occ, pe, pec, rdet, prst, susp} <= '0;
    end else begin
      conn_q <= conn;
      ovc_q  <= ovc;
      csc    <= w1c_next(csc, conn_chg, wr & wb.clr_csc);
      occ    <= w1c_next(occ, ovc_chg, wr & wb.clr_occ);
      pec    <= w1c_next(pec, dis_ev, wr & wb.clr_pec);
      if (dis_ev)  pe <= 1'b0;
      else if (wr) pe <= wb.w_en;
      if (wr) begin
        rdet <= wb.w_rdet;
        prst <= wb.w_rst;
        susp <= wb.w_susp;
      end
    end
  end

  assign rd     = port_pack(conn_q, csc, pe, pec, line, rdet, lowspd,
                            prst, ovc_q, occ, susp);
  assign en_o   = pe;
  assign rst_o  = prst;
  assign susp_o = susp;

endmodule

// File: rtl/usbhc_regbank.sv
`timescale 1ns/1ps
module usbhc_regbank
  import usbhc_regbank_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int NPORTS  = 2,
  parameter int FRNUM_W = 11,
  parameter int SOF_W   = 7,
  parameter int SOF_RST = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic                  bus_wr,
  input  logic [15:0]           bus_wdata,
  output logic [15:0]           bus_rdata,
  input  logic                  ev_ioc,
  input  logic                  ev_err,
  input  logic                  ev_resume,
  input  logic                  ev_hse,
  input  logic                  ev_perr,
  input  logic                  frame_end,
  input  logic [NPORTS-1:0]     port_conn,
  input  logic [2*NPORTS-1:0]   port_line,
  input  logic [NPORTS-1:0]     port_lowspd,
  input  logic [NPORTS-1:0]     port_ovc,
  input  logic [NPORTS-1:0]     port_dis,
  output logic                  irq,
  output logic                  run,
  output logic                  glb_reset,
  output logic                  glb_susp,
  output logic                  glb_resume,
  output logic                  sw_debug,
  output logic                  maxp_64,
  output logic [FRNUM_W-1:0]    frame_num,
  output logic [31:0]           flist_base,
  output logic [SOF_W-1:0]      sof_trim,
  output logic [NPORTS-1:0]     port_en_o,
  output logic [NPORTS-1:0]     port_rst_o,
  output logic [NPORTS-1:0]     port_susp_o
);

  localparam int WA_W = ADDR_W - 1;

  // named internal events, also used by the checker
  logic [WA_W-1:0] wsel;
  logic            even;
  logic            wr_cmd, wr_sts, wr_ien, wr_frnum, wr_flb_lo, wr_flb_hi, wr_sof;
  logic            hc_soft_clr;
  logic [4:0]      sts_ev;
  logic [7:0]      cmd_q;
  logic [5:0]      sts_bits;
  logic [3:0]      ien_q;
  port_wr_t        pw;
  logic [15:0]     port_rd [NPORTS];

  assign wsel      = bus_addr[ADDR_W-1:1];
  assign even      = ~bus_addr[0];
  assign wr_cmd    = bus_wr & even & (wsel == WA_W'(OFS_CMD / 2));
  assign wr_sts    = bus_wr & even & (wsel == WA_W'(OFS_STS / 2));
  assign wr_ien    = bus_wr & even & (wsel == WA_W'(OFS_IEN / 2));
  assign wr_frnum  = bus_wr & even & (wsel == WA_W'(OFS_FRNUM / 2));
  assign wr_flb_lo = bus_wr & even & (wsel == WA_W'(OFS_FLB_LO / 2));
  assign wr_flb_hi = bus_wr & even & (wsel == WA_W'(OFS_FLB_HI / 2));
  assign wr_sof    = bus_wr & even & (wsel == WA_W'(OFS_SOF / 2));
  assign sts_ev    = {ev_perr, ev_hse, ev_resume, ev_err, ev_ioc};
  assign pw        = port_wr_decode(bus_wdata);
  assign hc_soft_clr = cmd_q[CB_HCRST];

  usbhc_cmdsts u_cmdsts (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_clr  (hc_soft_clr),
    .wr_cmd    (wr_cmd),
    .wr_sts    (wr_sts),
    .wr_ien    (wr_ien),
    .cmd_wd    (bus_wdata[7:0]),
    .sts_wd    (bus_wdata[4:0]),
    .ien_wd    (bus_wdata[3:0]),
    .sts_ev    (sts_ev),
    .frame_end (frame_end),
    .cmd_q     (cmd_q),
    .sts_q     (sts_bits),
    .ien_q     (ien_q),
    .irq       (irq)
  );

  usbhc_framereg #(
    .FRNUM_W (FRNUM_W),
    .SOF_W   (SOF_W),
    .SOF_RST (SOF_RST)
  ) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_clr  (hc_soft_clr),
    .run       (cmd_q[CB_RUN]),
    .frame_end (frame_end),
    .wr_frnum  (wr_frnum),
    .wr_flb_lo (wr_flb_lo),
    .wr_flb_hi (wr_flb_hi),
    .wr_sof    (wr_sof),
    .wd        (bus_wdata),
    .frnum_q   (frame_num),
    .flb_q     (flist_base),
    .sof_q     (sof_trim)
  );

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    logic wr_p;
    assign wr_p = bus_wr & even & (wsel == WA_W'(OFS_PORT0 / 2 + p));
    usbhc_portreg u_port (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_clr (hc_soft_clr),
      .wr       (wr_p),
      .wb       (pw),
      .conn     (port_conn[p]),
      .line     (port_line[2*p +: 2]),
      .lowspd   (port_lowspd[p]),
      .ovc      (port_ovc[p]),
      .dis_ev   (port_dis[p]),
      .rd       (port_rd[p]),
      .en_o     (port_en_o[p]),
      .rst_o    (port_rst_o[p]),
      .susp_o   (port_susp_o[p])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (even) begin
      case (wsel)
        WA_W'(OFS_CMD / 2):    bus_rdata = {8'h00, cmd_q};
        WA_W'(OFS_STS / 2):    bus_rdata = {10'h000, sts_bits};
        WA_W'(OFS_IEN / 2):    bus_rdata = {12'h000, ien_q};
        WA_W'(OFS_FRNUM / 2):  bus_rdata = {{(16-FRNUM_W){1'b0}}, frame_num};
        WA_W'(OFS_FLB_LO / 2): bus_rdata = flist_base[15:0];
        WA_W'(OFS_FLB_HI / 2): bus_rdata = flist_base[31:16];
        WA_W'(OFS_SOF / 2):    bus_rdata = {{(16-SOF_W){1'b0}}, sof_trim};
        default:               bus_rdata = '0;
      endcase
      for (int i = 0; i < NPORTS; i++)
        if (wsel == WA_W'(OFS_PORT0 / 2 + i)) bus_rdata = port_rd[i];
    end
  end

  assign run        = cmd_q[CB_RUN];
  assign glb_reset  = cmd_q[CB_GRST];
  assign glb_susp   = cmd_q[CB_SUSP];
  assign glb_resume = cmd_q[CB_RSM];
  assign sw_debug   = cmd_q[CB_DBG];
  assign maxp_64    = cmd_q[CB_MAXP];

endmodule

// File: rtl/usbhc_regbank_chk.sv
`timescale 1ns/1ps
module usbhc_regbank_chk #(
  parameter int NPORTS  = 2,
  parameter int FRNUM_W = 11,
  parameter int SOF_W   = 7,
  parameter int SOF_RST = 64
) (
  input logic               clk,
  input logic               rst_n,
  input logic               hc_soft_clr,
  input logic               wr_cmd,
  input logic               wr_sts,
  input logic               wr_frnum,
  input logic [15:0]        bus_wdata,
  input logic [4:0]         sts_ev,
  input logic [5:0]         sts_bits,
  input logic               irq,
  input logic               run,
  input logic               frame_end,
  input logic [FRNUM_W-1:0] frame_num,
  input logic [SOF_W-1:0]   sof_trim,
  input logic [NPORTS-1:0]  port_dis,
  input logic [NPORTS-1:0]  port_en_o
);

  p_ioc_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sts_ev[0] && !hc_soft_clr |=> sts_bits[0]);

  p_ioc_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sts && bus_wdata[0] && !sts_ev[0] && !hc_soft_clr |=> !sts_bits[0]);

  p_halt_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cmd && bus_wdata[0] && !hc_soft_clr |=> !sts_bits[5]);

  p_hse_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sts_bits[3] || sts_bits[4] |-> irq);

  p_soft_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hc_soft_clr |=> !run && sts_bits[5] && sof_trim == SOF_W'(SOF_RST));

  p_frnum_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    run && frame_end && !wr_frnum && !hc_soft_clr
    |=> frame_num == FRNUM_W'($past(frame_num) + 1'b1));

  for (genvar p = 0; p < NPORTS; p++) begin : g_pchk
    p_port_dis_r12: assert property (@(posedge clk) disable iff (!rst_n)
      port_dis[p] |=> !port_en_o[p]);
  end

endmodule

bind usbhc_regbank usbhc_regbank_chk #(
  .NPORTS  (NPORTS),
  .FRNUM_W (FRNUM_W),
  .SOF_W   (SOF_W),
  .SOF_RST (SOF_RST)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .hc_soft_clr (hc_soft_clr),
  .wr_cmd      (wr_cmd),
  .wr_sts      (wr_sts),
  .wr_frnum    (wr_frnum),
  .bus_wdata   (bus_wdata),
  .sts_ev      (sts_ev),
  .sts_bits    (sts_bits),
  .irq         (irq),
  .run         (run),
  .frame_end   (frame_end),
  .frame_num   (frame_num),
  .sof_trim    (sof_trim),
  .port_dis    (port_dis),
  .port_en_o   (port_en_o)
);

// File: tb/usbhc_regbank_tb.sv
`timescale 1ns/1ps
module usbhc_regbank_tb;

  localparam int NP = 2;
  localparam int FW = 4;
  localparam int SW = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [4:0]    bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic [15:0]   bus_wdata = '0;
  logic [15:0]   bus_rdata;
  logic          ev_ioc = 0, ev_err = 0, ev_resume = 0, ev_hse = 0, ev_perr = 0;
  logic          frame_end = 0;
  logic [NP-1:0] port_conn = '0, port_lowspd = '0, port_ovc = '0, port_dis = '0;
  logic [2*NP-1:0] port_line = '0;
  logic          irq, run, glb_reset, glb_susp, glb_resume, sw_debug, maxp_64;
  logic [FW-1:0] frame_num;
  logic [31:0]   flist_base;
  logic [SW-1:0] sof_trim;
  logic [NP-1:0] port_en_o, port_rst_o, port_susp_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  usbhc_regbank #(.FRNUM_W(FW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ev_ioc(ev_ioc), .ev_err(ev_err), .ev_resume(ev_resume),
    .ev_hse(ev_hse), .ev_perr(ev_perr), .frame_end(frame_end),
    .port_conn(port_conn), .port_line(port_line), .port_lowspd(port_lowspd),
    .port_ovc(port_ovc), .port_dis(port_dis), .irq(irq), .run(run),
    .glb_reset(glb_reset), .glb_susp(glb_susp), .glb_resume(glb_resume),
    .sw_debug(sw_debug), .maxp_64(maxp_64), .frame_num(frame_num),
    .flist_base(flist_base), .sof_trim(sof_trim), .port_en_o(port_en_o),
    .port_rst_o(port_rst_o), .port_susp_o(port_susp_o)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic bwrite(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bread(input logic [4:0] a, output logic [15:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic rcheck(input string tag, input logic [4:0] a, input logic [15:0] exp);
    logic [15:0] d;
    bread(a, d);
    check(tag, {16'h0, d}, {16'h0, exp});
  endtask

  task automatic pulse_ev(input logic [4:0] m);
    @(negedge clk);
    {ev_perr, ev_hse, ev_resume, ev_err, ev_ioc} = m;
    @(negedge clk);
    {ev_perr, ev_hse, ev_resume, ev_err, ev_ioc} = '0;
  endtask

  task automatic pulse_frame();
    @(negedge clk); frame_end = 1'b1;
    @(negedge clk); frame_end = 1'b0;
  endtask

  task automatic do_hcreset();
    bwrite(5'd0, 16'h0002);
    @(negedge clk);
  endtask

  task automatic t_reset_vals();
    rcheck("R1 cmd", 0, 16'h0000);
    rcheck("R1 sts", 2, 16'h0020);
    rcheck("R1 ien", 4, 16'h0000);
    rcheck("R1 frnum", 6, 16'h0000);
    rcheck("R1 flb lo", 8, 16'h0000);
    rcheck("R1 flb hi", 10, 16'h0000);
    rcheck("R1 sof", 12, 16'h0040);
    rcheck("R1 port0", 16, 16'h0080);
    rcheck("R1 port1", 18, 16'h0080);
    check("R1 irq", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_command();
    do_hcreset();
    bwrite(0, 16'hFFFD);
    rcheck("R2 cmd readback", 0, 16'h00FD);
    check("R2 cmd outputs", {26'h0, maxp_64, sw_debug, glb_resume, glb_susp, glb_reset, run}, 32'h3F);
    bwrite(0, 16'h0080);
    rcheck("R2 cmd second", 0, 16'h0080);
    check("R2 run low", {26'h0, maxp_64, sw_debug, glb_resume, glb_susp, glb_reset, run}, 32'h20);
  endtask

  task automatic t_status_w1c();
    do_hcreset();
    pulse_ev(5'h1F);
    rcheck("R3 all set", 2, 16'h003F);
    bwrite(2, 16'h0000);
    rcheck("R3 zero write", 2, 16'h003F);
    bwrite(2, 16'h0003);
    rcheck("R3 clear two", 2, 16'h003C);
    @(negedge clk);
    bus_addr = 2; bus_wdata = 16'h0001; bus_wr = 1'b1; ev_ioc = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; ev_ioc = 1'b0;
    rcheck("R3 event wins", 2, 16'h003D);
    bwrite(2, 16'h001F);
    rcheck("R3 all cleared", 2, 16'h0020);
  endtask

  task automatic t_halted();
    do_hcreset();
    bwrite(2, 16'h0020);
    rcheck("R4 halted read-only", 2, 16'h0020);
    bwrite(0, 16'h0001);
    rcheck("R4 run clears", 2, 16'h0000);
    pulse_frame();
    rcheck("R4 frame while running", 2, 16'h0000);
    bwrite(0, 16'h0000);
    rcheck("R4 stop pending", 2, 16'h0000);
    pulse_frame();
    rcheck("R4 halted after frame", 2, 16'h0020);
  endtask

  task automatic t_irq();
    do_hcreset();
    bwrite(4, 16'hFFFF);
    rcheck("R5 ien bits", 4, 16'h000F);
    bwrite(4, 16'h0000);
    pulse_ev(5'h01);
    check("R5 ioc masked", {31'h0, irq}, 0);
    bwrite(4, 16'h0004);
    check("R5 ioc enabled", {31'h0, irq}, 1);
    bwrite(2, 16'h0001);
    check("R5 ioc cleared", {31'h0, irq}, 0);
    pulse_ev(5'h02);
    check("R5 err wrong enable", {31'h0, irq}, 0);
    bwrite(4, 16'h0001);
    check("R5 err enabled", {31'h0, irq}, 1);
    bwrite(2, 16'h0002);
    bwrite(4, 16'h0002);
    pulse_ev(5'h04);
    check("R5 resume enabled", {31'h0, irq}, 1);
    bwrite(2, 16'h0004);
    bwrite(4, 16'h0000);
    pulse_ev(5'h08);
    check("R5 hse unmasked", {31'h0, irq}, 1);
    bwrite(2, 16'h0008);
    pulse_ev(5'h10);
    check("R5 perr unmasked", {31'h0, irq}, 1);
    bwrite(2, 16'h0010);
    check("R5 idle", {31'h0, irq}, 0);
  endtask

  task automatic t_hcreset();
    do_hcreset();
    bwrite(12, 16'h0005);
    bwrite(4, 16'h000F);
    bwrite(6, 16'h0003);
    pulse_ev(5'h01);
    bwrite(0, 16'h0043);
    rcheck("R6 bit visible", 0, 16'h0043);
    @(negedge clk);
    rcheck("R6 cmd reset", 0, 16'h0000);
    rcheck("R6 sts reset", 2, 16'h0020);
    rcheck("R6 ien reset", 4, 16'h0000);
    rcheck("R6 frnum reset", 6, 16'h0000);
    rcheck("R6 sof reset", 12, 16'h0040);
  endtask

  task automatic t_frnum();
    do_hcreset();
    bwrite(6, 16'hFFFF);
    rcheck("R7 width", 6, 16'h000F);
    pulse_frame();
    rcheck("R7 stopped hold", 6, 16'h000F);
    bwrite(0, 16'h0001);
    bwrite(6, 16'h000E);
    pulse_frame();
    rcheck("R7 count", 6, 16'h000F);
    pulse_frame();
    rcheck("R7 wrap", 6, 16'h0000);
    check("R7 output", {28'h0, frame_num}, 0);
    @(negedge clk);
    bus_addr = 6; bus_wdata = 16'h0009; bus_wr = 1'b1; frame_end = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; frame_end = 1'b0;
    rcheck("R7 write beats count", 6, 16'h0009);
  endtask

  task automatic t_flbase();
    do_hcreset();
    bwrite(8, 16'h1234);
    bwrite(10, 16'hABCD);
    rcheck("R8 lo", 8, 16'h1234);
    rcheck("R8 hi", 10, 16'hABCD);
    check("R8 out", flist_base, 32'hABCD1234);
  endtask

  task automatic t_sof();
    do_hcreset();
    bwrite(12, 16'hFFFF);
    rcheck("R9 width", 12, 16'h007F);
    check("R9 out", {25'h0, sof_trim}, 32'h7F);
  endtask

  task automatic t_port_ro();
    do_hcreset();
    @(negedge clk);
    port_line = 4'b1001; port_lowspd = 2'b01;
    rcheck("R10 port0 levels", 16, 16'h0190);
    rcheck("R10 port1 levels", 18, 16'h00A0);
    bwrite(16, 16'hE000);
    rcheck("R10 reserved bits", 16, 16'h0190);
    port_line = '0; port_lowspd = '0;
  endtask

  task automatic t_port_change();
    do_hcreset();
    @(negedge clk); port_conn[1] = 1'b1;
    @(negedge clk);
    rcheck("R11 connect latched", 18, 16'h0083);
    rcheck("R11 other port quiet", 16, 16'h0080);
    bwrite(18, 16'h0000);
    rcheck("R11 zero write", 18, 16'h0083);
    bwrite(18, 16'h0002);
    rcheck("R11 cleared", 18, 16'h0081);
    @(negedge clk);
    port_conn[1] = 1'b0; bus_addr = 18; bus_wdata = 16'h0002; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    rcheck("R11 change wins", 18, 16'h0082);
    bwrite(18, 16'h0002);
    @(negedge clk); port_ovc[0] = 1'b1;
    @(negedge clk);
    rcheck("R11 ovc latched", 16, 16'h0C80);
    bwrite(16, 16'h0800);
    rcheck("R11 ovc change cleared", 16, 16'h0480);
    @(negedge clk); port_ovc[0] = 1'b0;
    @(negedge clk);
    rcheck("R11 ovc gone", 16, 16'h0880);
    bwrite(16, 16'h0800);
  endtask

  task automatic t_port_enable();
    do_hcreset();
    bwrite(16, 16'h0004);
    rcheck("R12 enabled", 16, 16'h0084);
    check("R12 en out", {30'h0, port_en_o}, 32'h1);
    @(negedge clk); port_dis[0] = 1'b1;
    @(negedge clk); port_dis[0] = 1'b0;
    rcheck("R12 hw disable", 16, 16'h0088);
    check("R12 en out low", {30'h0, port_en_o}, 32'h0);
    bwrite(16, 16'h0008);
    rcheck("R12 change cleared", 16, 16'h0080);
    @(negedge clk);
    bus_addr = 16; bus_wdata = 16'h0004; bus_wr = 1'b1; port_dis[0] = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; port_dis[0] = 1'b0;
    rcheck("R12 disable beats write", 16, 16'h0088);
  endtask

  task automatic t_port_rw();
    do_hcreset();
    bwrite(18, 16'h1240);
    rcheck("R13 rw bits", 18, 16'h12C0);
    check("R13 outputs", {28'h0, port_rst_o, port_susp_o}, 32'b1010);
    bwrite(18, 16'h0000);
    rcheck("R13 cleared", 18, 16'h0080);
  endtask

  task automatic t_unmapped();
    do_hcreset();
    bwrite(14, 16'hFFFF);
    bwrite(20, 16'hFFFF);
    bwrite(1, 16'hFFFF);
    rcheck("R14 hole 14", 14, 16'h0000);
    rcheck("R14 past ports", 20, 16'h0000);
    rcheck("R14 odd", 1, 16'h0000);
    rcheck("R14 cmd untouched", 0, 16'h0000);
    rcheck("R14 sof untouched", 12, 16'h0040);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_vals();
    t_command();
    t_status_w1c();
    t_halted();
    t_irq();
    t_hcreset();
    t_frnum();
    t_flbase();
    t_sof();
    t_port_ro();
    t_port_change();
    t_port_enable();
    t_port_rw();
    t_unmapped();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule